// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block owns the program-memory fetch address of a small processor core and runs counted loops entirely in hardware. A loop-start command records a loop context on an internal stack: the address that follows the loop-start instruction (the loop top), the last address of the body (the loop end) and an iteration count. Each time the fetch address advances past the innermost loop's end address, the count is tested and decremented in the same cycle. The next fetch address is either the loop top or the sequential successor, so no jump or decrement-and-test instruction is needed and no cycle is lost.

Loops nest up to a parameterised stack depth. Only the innermost context is compared against the fetch address. A branch request, which may be conditioned on an external flag, overrides sequential and loop-back addressing for its cycle and leaves the stack alone. An explicit loop-exit command discards the innermost context. Pushing onto a full stack and popping an empty one are both ignored, and each sets its own sticky error flag.

The control core is a two-state machine. In LINEAR the stack is empty and addresses only step or branch. In LOOPING at least one context is live. The transition ENTER (LINEAR to LOOPING) fires on an accepted push. The transition EXIT (LOOPING to LINEAR) fires when the last context is popped, whether by termination or by the exit command. The self-transitions STAY_LINEAR and STAY_LOOPING cover every other cycle.

Top module: `zol_sequencer`

## Requirements
- R1: After reset `fetch_addr` equals the `RESET_ADDR` parameter (0 by default), `loop_depth` is 0, and `loop_active`, `stack_ovf` and `stack_unf` are all 0.
- R2: With no taken branch, `fetch_addr` becomes `fetch_addr`+1 on a cycle with `advance`=1 and holds on a cycle with `advance`=0. A held cycle at the loop end address does not consume an iteration.
- R3: `loop_start`=1 pushes a context whose top is `fetch_addr`+1, whose end is `loop_end` and whose count is `loop_count`. `loop_depth` rises by one on the next cycle.
- R4: When `advance`=1 and `fetch_addr` equals the innermost end address with a count above 1, the very next `fetch_addr` is the loop top and the count drops by one.
- R5: When `advance`=1 and `fetch_addr` equals the innermost end address with a count of 1, the context is popped and the next `fetch_addr` is `fetch_addr`+1.
- R6: A `loop_count` of 0 runs the loop body exactly once, the same as a count of 1.
- R7: Loops nest up to `DEPTH` (6) contexts. Only the innermost is compared against the fetch address, and an outer loop resumes its own iterations after an inner loop terminates.
- R8: A branch is taken when `branch_req`=1 and either `branch_cond`=0 or `cond_flag`=1. A taken branch makes the next `fetch_addr` equal `branch_target` even at a loop end. When `branch_cond`=1 and `cond_flag`=0 the branch is ignored and addressing proceeds normally. Branches never change `loop_depth`.
- R9: A `loop_start` while `loop_depth`=`DEPTH` leaves the stack unchanged and sets `stack_ovf`, which stays set until reset.
- R10: `loop_pop`=1 without `loop_start` removes the innermost context. With an empty stack it sets `stack_unf`, which stays set until reset. `loop_start` takes precedence over `loop_pop` in the same cycle.
- R11: `loop_active` is 1 exactly when `loop_depth` is non-zero (state LOOPING), and 0 otherwise (state LINEAR).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| advance | input | 1 | Sequential-advance strobe |
| loop_start | input | 1 | Push a new loop context |
| loop_end | input | AW (16) | Last address of the new loop body |
| loop_count | input | CW (16) | Iteration count of the new loop |
| loop_pop | input | 1 | Discard the innermost loop context |
| branch_req | input | 1 | Branch request |
| branch_cond | input | 1 | Branch is conditional on `cond_flag` |
| cond_flag | input | 1 | Condition flag |
| branch_target | input | AW (16) | Branch destination address |
| fetch_addr | output | AW (16) | Program-memory fetch address |
| loop_depth | output | $clog2(DEPTH+1) (3) | Number of live loop contexts |
| loop_active | output | 1 | State is LOOPING |
| stack_ovf | output | 1 | Sticky push-on-full flag |
| stack_unf | output | 1 | Sticky pop-on-empty flag |

## Verification
The bench builds the block with its defaults: 16-bit addresses and counts, a six-entry stack and a reset address of 0. Six entries is small enough that seven back-to-back pushes reach the overflow corner and then drain to underflow within a few dozen cycles. Short loop bodies at low addresses allow a two-level nest, the same-cycle loop-back, the single-instruction loop and a branch at a loop end to be traced address by address.

// File: rtl/zol_pkg.sv
package zol_pkg;

    typedef enum logic [0:0] {
        SEQ_LINEAR  = 1'b0,
        SEQ_LOOPING = 1'b1
    } seq_state_t;

    typedef enum logic [1:0] {
        SEL_HOLD   = 2'd0,
        SEL_SEQ    = 2'd1,
        SEL_TOP    = 2'd2,
        SEL_BRANCH = 2'd3
    } addr_sel_t;

endpackage

// File: rtl/zol_loop_stack.sv
module zol_loop_stack #(
    parameter int AW    = 16,
    parameter int CW    = 16,
    parameter int DEPTH = 6,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_top,
    input  logic [AW-1:0] push_end,
    input  logic [CW-1:0] push_cnt,
    input  logic          pop,
    input  logic          dec,
    output logic [AW-1:0] tos_top,
    output logic [AW-1:0] tos_end,
    output logic [CW-1:0] tos_cnt,
    output logic [DW-1:0] depth,
    output logic          empty,
    output logic          full
);

    localparam logic [DW-1:0] DEPTH_W = DW'(DEPTH);
    localparam int            IW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] top_q [DEPTH];
    logic [AW-1:0] end_q [DEPTH];
    logic [CW-1:0] cnt_q [DEPTH];
    logic [DW-1:0] depth_q;
    logic [IW-1:0] tos_idx;

    assign empty = (depth_q == '0);
    assign full  = (depth_q == DEPTH_W);
    assign depth = depth_q;

    always_comb begin
        if (empty) tos_idx = '0;
        else       tos_idx = IW'(depth_q - 1'b1);
    end

    assign tos_top = top_q[tos_idx];
    assign tos_end = end_q[tos_idx];
    assign tos_cnt = cnt_q[tos_idx];

    always_ff @(posedge clk) begin
        if (!rst_n)                depth_q <= '0;
        else if (push && !full)    depth_q <= depth_q + 1'b1;
        else if (pop && !empty)    depth_q <= depth_q - 1'b1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                top_q[i] <= '0;
                end_q[i] <= '0;
                cnt_q[i] <= '0;
            end else if (push && depth_q == DW'(i)) begin
                top_q[i] <= push_top;
                end_q[i] <= push_end;
                cnt_q[i] <= push_cnt;
            end else if (dec && depth_q == DW'(i + 1)) begin
                cnt_q[i] <= cnt_q[i] - 1'b1;
            end
        end
    end

    // R7: depth never exceeds the configured number of entries
    p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= DEPTH_W);

    // R9: caller never pushes onto a full stack
    p_no_push_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R10: caller never pops or decrements an empty stack
    p_no_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop || dec) |-> !empty);

    // R3: an accepted push stores the requested end address on top
    p_push_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (tos_end == $past(push_end) && depth == $past(depth) + 1'b1));

endmodule

// File: rtl/zol_next_decide.sv
module zol_next_decide
    import zol_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          loop_start,
    input  logic          loop_pop,
    input  logic          branch_taken,
    input  logic          stk_empty,
    input  logic          stk_full,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] tos_end,
    input  logic [CW-1:0] tos_cnt,
    output addr_sel_t     sel,
    output logic          do_push,
    output logic          do_pop,
    output logic          do_dec,
    output logic          set_ovf,
    output logic          set_unf
);

    logic end_hit;
    logic more_iters;
    logic loop_back;
    logic pop_cmd;

    assign pop_cmd    = loop_pop && !loop_start;
    assign end_hit    = advance && !branch_taken && !loop_start && !loop_pop
                        && !stk_empty && (pc == tos_end);
    assign more_iters = (tos_cnt > CW'(1));
    assign loop_back  = end_hit && more_iters;

    always_comb begin
        if (branch_taken)  sel = SEL_BRANCH;
        else if (!advance) sel = SEL_HOLD;
        else if (loop_back) sel = SEL_TOP;
        else               sel = SEL_SEQ;
    end

    always_comb begin
        do_push = loop_start && !stk_full;
        set_ovf = loop_start && stk_full;
        do_dec  = loop_back;
        do_pop  = (pop_cmd && !stk_empty) || (end_hit && !more_iters);
        set_unf = pop_cmd && stk_empty;
    end

    // R10: at most one stack operation per cycle
    p_one_stack_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_push, do_pop, do_dec}));

    // R8: a taken branch never consumes a loop iteration
    p_branch_no_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken |-> !do_dec);

endmodule

// File: rtl/zol_sequencer.sv
module zol_sequencer
    import zol_pkg::*;
#(
    parameter int            AW         = 16,
    parameter int            CW         = 16,
    parameter int            DEPTH      = 6,
    parameter logic [AW-1:0] RESET_ADDR = '0,
    localparam int           DW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          loop_start,
    input  logic [AW-1:0] loop_end,
    input  logic [CW-1:0] loop_count,
    input  logic          loop_pop,
    input  logic          branch_req,
    input  logic          branch_cond,
    input  logic          cond_flag,
    input  logic [AW-1:0] branch_target,
    output logic [AW-1:0] fetch_addr,
    output logic [DW-1:0] loop_depth,
    output logic          loop_active,
    output logic          stack_ovf,
    output logic          stack_unf
);

    seq_state_t    state_q, state_d;
    addr_sel_t     sel;
    logic [AW-1:0] pc_q, pc_d;
    logic          ovf_q, unf_q;
    logic          branch_taken;
    logic          do_push, do_pop, do_dec, set_ovf, set_unf;
    logic [AW-1:0] tos_top, tos_end;
    logic [CW-1:0] tos_cnt, push_cnt;
    logic [DW-1:0] depth;
    logic          stk_empty, stk_full;

    assign branch_taken = branch_req && (!branch_cond || cond_flag);
    assign push_cnt     = (loop_count == '0) ? CW'(1) : loop_count;

    zol_loop_stack #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_push),
        .push_top (pc_q + 1'b1),
        .push_end (loop_end),
        .push_cnt (push_cnt),
        .pop      (do_pop),
        .dec      (do_dec),
        .tos_top  (tos_top),
        .tos_end  (tos_end),
        .tos_cnt  (tos_cnt),
        .depth    (depth),
        .empty    (stk_empty),
        .full     (stk_full)
    );

    zol_next_decide #(.AW(AW), .CW(CW)) u_decide (
        .clk          (clk),
        .rst_n        (rst_n),
        .advance      (advance),
        .loop_start   (loop_start),
        .loop_pop     (loop_pop),
        .branch_taken (branch_taken),
        .stk_empty    (stk_empty),
        .stk_full     (stk_full),
        .pc           (pc_q),
        .tos_end      (tos_end),
        .tos_cnt      (tos_cnt),
        .sel          (sel),
        .do_push      (do_push),
        .do_pop       (do_pop),
        .do_dec       (do_dec),
        .set_ovf      (set_ovf),
        .set_unf      (set_unf)
    );

    always_comb begin
        unique case (sel)
            SEL_BRANCH: pc_d = branch_target;
            SEL_TOP:    pc_d = tos_top;
            SEL_SEQ:    pc_d = pc_q + 1'b1;
            SEL_HOLD:   pc_d = pc_q;
            default:    pc_d = pc_q;
        endcase
    end

    // Next-state logic: ENTER, EXIT, STAY_LINEAR, STAY_LOOPING
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_LINEAR:  if (do_push) state_d = SEQ_LOOPING;
            SEQ_LOOPING: if (do_pop && depth == DW'(1)) state_d = SEQ_LINEAR;
            default:     state_d = SEQ_LINEAR;
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_LINEAR;
            pc_q    <= RESET_ADDR;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            ovf_q   <= ovf_q | set_ovf;
            unf_q   <= unf_q | set_unf;
        end
    end

    // Output process
    always_comb begin
        fetch_addr  = pc_q;
        loop_depth  = depth;
        loop_active = (state_q == SEQ_LOOPING);
        stack_ovf   = ovf_q;
        stack_unf   = unf_q;
    end

    // R11: the state machine tracks the stack occupancy
    p_state_depth_r11: assert property (@(posedge clk) disable iff (!rst_n)
        loop_active == (loop_depth != '0));

    // R4: loop-back lands on the loop top with no gap
    p_loopback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !branch_req && !loop_start && !loop_pop && loop_active
         && fetch_addr == tos_end && tos_cnt > CW'(1))
        |=> fetch_addr == $past(tos_top));

    // R8: a taken branch wins the next address
    p_branch_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken |=> fetch_addr == $past(branch_target));

    // R2: without advance or branch the address holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !branch_taken) |=> $stable(fetch_addr));

    // R9: overflow flag is sticky
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stack_ovf |=> stack_ovf);

    // R10: underflow flag is sticky
    p_unf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stack_unf |=> stack_unf);

endmodule

// File: tb/zol_sequencer_bench.sv
module zol_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        advance, loop_start, loop_pop;
    logic        branch_req, branch_cond, cond_flag;
    logic [15:0] loop_end, loop_count, branch_target;
    logic [15:0] fetch_addr;
    logic [2:0]  loop_depth;
    logic        loop_active, stack_ovf, stack_unf;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    zol_sequencer u_zol_sequencer (
        .clk(clk), .rst_n(rst_n), .advance(advance), .loop_start(loop_start),
        .loop_end(loop_end), .loop_count(loop_count), .loop_pop(loop_pop),
        .branch_req(branch_req), .branch_cond(branch_cond), .cond_flag(cond_flag),
        .branch_target(branch_target), .fetch_addr(fetch_addr),
        .loop_depth(loop_depth), .loop_active(loop_active),
        .stack_ovf(stack_ovf), .stack_unf(stack_unf)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        advance = 0; loop_start = 0; loop_pop = 0;
        branch_req = 0; branch_cond = 0; cond_flag = 0;
        loop_end = 0; loop_count = 0; branch_target = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        step(); step();
        rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 addr", fetch_addr, 0);
        chk("R1 depth", loop_depth, 0);
        chk("R1 flags", {loop_active, stack_ovf, stack_unf}, 0);
    endtask

    task automatic t_linear();
        do_reset();
        advance = 1;
        for (int i = 1; i <= 3; i++) begin
            step();
            chk("R2 advance", fetch_addr, i);
        end
        advance = 0;
        step(); step();
        chk("R2 hold", fetch_addr, 3);
    endtask

    task automatic t_single_loop();
        int exp_seq[10] = '{3, 4, 5, 3, 4, 5, 3, 4, 5, 6};
        do_reset();
        advance = 1;
        step(); step();
        chk("R3 at start", fetch_addr, 2);
        loop_start = 1; loop_end = 5; loop_count = 3;
        step();
        loop_start = 0;
        chk("R3 top", fetch_addr, exp_seq[0]);
        chk("R3 depth", loop_depth, 1);
        chk("R11 active", loop_active, 1);
        for (int i = 1; i < 10; i++) begin
            step();
            chk((i == 9) ? "R5 fallthrough" : "R4 loopback", fetch_addr, exp_seq[i]);
        end
        chk("R5 depth", loop_depth, 0);
        chk("R11 idle", loop_active, 0);
    endtask

    task automatic t_zero_count();
        do_reset();
        advance = 1; loop_start = 1; loop_end = 2; loop_count = 0;
        step();
        loop_start = 0;
        step(); step();
        chk("R6 once", fetch_addr, 3);
        chk("R6 depth", loop_depth, 0);
    endtask

    task automatic t_nested();
        int exp_seq[17] = '{1, 2, 3, 2, 3, 4, 5, 6, 1, 2, 3, 2, 3, 4, 5, 6, 7};
        do_reset();
        advance = 1; loop_start = 1; loop_end = 6; loop_count = 2;
        step();
        chk("R7 outer", fetch_addr, exp_seq[0]);
        for (int i = 1; i < 17; i++) begin
            loop_start = (fetch_addr == 1);
            loop_end   = 3;
            loop_count = 2;
            step();
            if (i == 1) chk("R7 nest depth", loop_depth, 2);
            chk("R7 nested seq", fetch_addr, exp_seq[i]);
        end
        loop_start = 0;
        chk("R7 drained", loop_depth, 0);
    endtask

    task automatic t_branch();
        do_reset();
        advance = 1; loop_start = 1; loop_end = 2; loop_count = 5;
        step();
        loop_start = 0;
        step();
        chk("R8 at end", fetch_addr, 2);
        branch_req = 1; branch_target = 16'h40;
        step();
        chk("R8 overrides loop", fetch_addr, 16'h40);
        chk("R8 stack kept", loop_depth, 1);
        branch_cond = 1; cond_flag = 0; branch_target = 16'h80;
        step();
        chk("R8 cond false", fetch_addr, 16'h41);
        cond_flag = 1;
        step();
        chk("R8 cond true", fetch_addr, 16'h80);
        chk("R8 depth unchanged", loop_depth, 1);
    endtask

    task automatic t_overflow();
        do_reset();
        loop_start = 1; loop_end = 16'h100; loop_count = 2;
        for (int i = 0; i < 6; i++) step();
        chk("R9 full", loop_depth, 6);
        chk("R9 no ovf yet", stack_ovf, 0);
        step();
        loop_start = 0;
        chk("R9 ignored push", loop_depth, 6);
        chk("R9 ovf set", stack_ovf, 1);
        loop_pop = 1;
        for (int i = 0; i < 6; i++) step();
        chk("R10 drained", loop_depth, 0);
        chk("R10 no unf yet", stack_unf, 0);
        step();
        loop_pop = 0;
        chk("R10 unf set", stack_unf, 1);
        step();
        chk("R9 ovf sticky", stack_ovf, 1);
        chk("R10 unf sticky", stack_unf, 1);
    endtask

    task automatic t_exit();
        do_reset();
        advance = 1; loop_start = 1; loop_end = 3; loop_count = 4;
        step();
        loop_start = 0; loop_pop = 1;
        step();
        loop_pop = 0;
        chk("R10 exit depth", loop_depth, 0);
        step(); step();
        chk("R10 no loopback", fetch_addr, 4);
        loop_start = 1; loop_pop = 1; loop_end = 9; loop_count = 2;
        step();
        loop_start = 0; loop_pop = 0;
        chk("R10 start wins", loop_depth, 1);
        chk("R10 start wins unf", stack_unf, 0);
    endtask

    task automatic t_hold_at_end();
        do_reset();
        advance = 1; loop_start = 1; loop_end = 1; loop_count = 2;
        step();
        loop_start = 0; advance = 0;
        step(); step();
        chk("R2 held at end", fetch_addr, 1);
        chk("R2 held depth", loop_depth, 1);
        advance = 1;
        step();
        chk("R4 single instr loop", fetch_addr, 1);
        step();
        chk("R5 single instr exit", fetch_addr, 2);
    endtask

    initial begin
        rst_n = 0;
        idle();
        t_reset();
        t_linear();
        t_single_loop();
        t_zero_count();
        t_nested();
        t_branch();
        t_overflow();
        t_exit();
        t_hold_at_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule